// File: doc/BRIEF.md
# Sigma-Delta Sinc Decimator

This block turns the 1-bit output stream of a sigma-delta modulator into signed multi-bit samples. It uses a cascaded-integrator-comb structure whose order can be chosen at run time. The modulator clock arrives as an input and is sampled by the system clock. Each rising edge of the modulator clock delivers one data bit. After a programmable number of bits, the block produces one sample and raises a one-cycle data-ready strobe.

Four filter types are available: first, second and third order sinc, and a fast-settling second-order variant. The fast variant restarts its window at every output, so its first sample is valid after a single decimation period. The other types suppress their first unsettled samples. Clearing the enable, or pulsing the sync input, empties the filter state and restarts the decimation phase, so several instances can be aligned to a common event.

Samples are delivered at full precision, sign-extended to 32 bits. Alternatively they can be scaled by an arithmetic right shift and saturated to a signed 16-bit value. Filter type and ratio are expected to change only while the block is disabled. The shift amount may change between samples.

Top module: `sinc_decim`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dready` is 0 and `sample` is 0.
- R2: Each rising edge of `mod_clk` with `enable` high feeds one bit, mapped as 1 → +1 and 0 → −1; with a ratio of 1 and type Sinc1, every bit yields a sample of +1 or −1.
- R3: Type code 0 (Sinc1) outputs the sum of the last R mapped bits, where R = `osr_m1` + 1.
- R4: Type codes 1 (Sinc2) and 3 (Sinc3) output the mapped bitstream convolved with two or three cascaded length-R boxcars, evaluated at every R-th bit.
- R5: Type code 2 (fast) outputs the sum of w·x over the R bits of the current window, where the first bit of the window has weight R and the last has weight 1; every window yields a sample, with none suppressed.
- R6: Exactly one sample is produced per R input bits, for R from 1 to 2^OSR_BITS (256 by default).
- R7: After enable rises or after a sync pulse, Sinc2 suppresses its first sample and Sinc3 its first two; Sinc1 and the fast type suppress none.
- R8: With `word16` = 0, `sample` is the full-precision result, sign-extended to 32 bits, exact at full scale (±2^24 for Sinc3 at R = 256).
- R9: With `word16` = 1, the result is shifted right arithmetically by `shift` (0 to 31), saturated to [−32768, 32767], and sign-extended to 32 bits.
- R10: While `enable` is low, bits are ignored, no `dready` occurs, and the filter state is cleared.
- R11: A one-cycle `sync` pulse clears the filter state and restarts the decimation phase at the next bit.
- R12: `dready` is a single-cycle pulse, issued together with the new `sample`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_clk | input | 1 | Modulator clock, sampled by `clk` |
| mod_data | input | 1 | Modulator bitstream |
| enable | input | 1 | Filter enable; low clears state |
| sync | input | 1 | One-cycle realignment pulse |
| filt_sel | input | 2 | 0 Sinc1, 1 Sinc2, 2 fast, 3 Sinc3 |
| osr_m1 | input | OSR_BITS | Decimation ratio minus one |
| word16 | input | 1 | 1 selects scaled 16-bit output |
| shift | input | 5 | Right shift applied in 16-bit mode |
| dready | output | 1 | One-cycle sample-valid strobe |
| sample | output | 32 | Output sample |

## Verification
Pseudo-random bitstreams at several ratios separate the filter orders, because each order weights past bits differently. A wrong tap count or a wrong comb delay then changes almost every sample. Alternating bits keep the integrators near zero, while long runs of ones and zeros drive Sinc2 and Sinc3 to full scale at a ratio of 256. These full-scale runs expose missing integrator width, broken sign extension and both saturation limits. A ratio of 1 isolates the bit mapping. Extra bits fed while disabled, and a sync pulse placed mid-window, show whether stale state or an old phase leaks into later samples.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;

    typedef enum logic [1:0] {
        FT_SINC1 = 2'd0,
        FT_SINC2 = 2'd1,
        FT_FAST  = 2'd2,
        FT_SINC3 = 2'd3
    } filt_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
    } out_t;

    // Number of cascaded integrator/comb pairs that form the output.
    function automatic logic [1:0] order_of(filt_e t);
        case (t)
            FT_SINC1: return 2'd1;
            FT_SINC2: return 2'd2;
            FT_FAST:  return 2'd2;
            default:  return 2'd3;
        endcase
    endfunction

    // Samples to discard after a restart before the window is full.
    function automatic logic [1:0] settle_need(filt_e t);
        case (t)
            FT_SINC2: return 2'd1;
            FT_SINC3: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic [15:0] sat16(logic signed [31:0] v);
        if (v > 32'sd32767)
            return 16'h7fff;
        else if (v < -32'sd32768)
            return 16'h8000;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
    parameter int W      = 26,
    parameter int STAGES = 3
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       step,
    input  logic                       fresh,
    input  logic                       bit_in,
    output logic [STAGES-1:0][W-1:0]   acc
);

    logic [STAGES-1:0][W-1:0] nxt;
    logic [W-1:0]             unit;

    assign unit = bit_in ? W'(1) : {W{1'b1}};

    // Each stage adds the freshly updated value of the stage before it;
    // "fresh" drops the old contents so a new window starts from zero.
    always_comb begin
        logic [W-1:0] carry;
        carry = unit;
        for (int k = 0; k < STAGES; k++) begin
            carry  = (fresh ? '0 : acc[k]) + carry;
            nxt[k] = carry;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            acc <= '0;
        else if (step)
            acc <= nxt;
    end

    // R2
    bit_map_chk: assert property (@(posedge clk) disable iff (clr)
        (step && !fresh) |=>
            ((acc[0] - $past(acc[0])) == ($past(bit_in) ? W'(1) : {W{1'b1}})));

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
    parameter int W      = 26,
    parameter int STAGES = 3
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           fire,
    input  logic [1:0]     order,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout
);

    logic [STAGES-1:0][W-1:0] dly;
    logic [STAGES:0][W-1:0]   tap;

    // Differentiator chain at the decimated rate: tap[k+1] = tap[k] - previous tap[k].
    always_comb begin
        logic [W-1:0] run;
        run    = din;
        tap[0] = din;
        for (int k = 0; k < STAGES; k++) begin
            run      = run - dly[k];
            tap[k+1] = run;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            dly <= '0;
        else if (fire)
            for (int k = 0; k < STAGES; k++)
                dly[k] <= tap[k];
    end

    assign dout = tap[order];

endmodule

// File: rtl/sinc_fmt.sv
module sinc_fmt #(
    parameter int W = 26
) (
    input  logic [W-1:0]  full,
    input  logic          word16,
    input  logic [4:0]    shift,
    output logic [31:0]   word
);
    import sinc_decim_pkg::*;

    logic signed [31:0] wide;
    logic signed [31:0] scaled;
    logic [15:0]        narrow;

    assign wide   = {{(32-W){full[W-1]}}, full};
    assign scaled = wide >>> shift;
    assign narrow = sat16(scaled);
    assign word   = word16 ? {{16{narrow[15]}}, narrow} : wide;

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
    parameter int OSR_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mod_clk,
    input  logic                 mod_data,
    input  logic                 enable,
    input  logic                 sync,
    input  logic [1:0]           filt_sel,
    input  logic [OSR_BITS-1:0]  osr_m1,
    input  logic                 word16,
    input  logic [4:0]           shift,
    output logic                 dready,
    output logic [31:0]          sample
);
    import sinc_decim_pkg::*;

    localparam int STAGES = 3;
    localparam int ACC_W  = STAGES * OSR_BITS + 2;

    filt_e                        ftype;
    logic                         clr;
    logic                         mclk_d;
    logic                         step;
    logic [OSR_BITS-1:0]          phase;
    logic                         dec_q;
    logic                         fresh_q;
    logic [STAGES-1:0][ACC_W-1:0] acc;
    logic [ACC_W-1:0]             comb_in;
    logic [ACC_W-1:0]             comb_out;
    logic [ACC_W-1:0]             full;
    logic [31:0]                  fmt_word;
    logic [1:0]                   order;
    logic [1:0]                   need;
    logic [1:0]                   seen;
    out_t                         out_q;

    assign ftype = filt_e'(filt_sel);
    assign order = order_of(ftype);
    assign need  = settle_need(ftype);
    assign clr   = rst | ~enable | sync;

    // Modulator clock edge detection: one bit per rising edge.
    always_ff @(posedge clk) begin
        if (rst)
            mclk_d <= 1'b0;
        else
            mclk_d <= mod_clk;
    end

    assign step = mod_clk & ~mclk_d & enable & ~sync;

    // Decimation phase counter.
    always_ff @(posedge clk) begin
        if (clr) begin
            phase <= '0;
            dec_q <= 1'b0;
        end else begin
            dec_q <= step && (phase == osr_m1);
            if (step)
                phase <= (phase == osr_m1) ? '0 : phase + 1'b1;
        end
    end

    // Fast type: the first bit after each output starts a new window.
    always_ff @(posedge clk) begin
        if (clr)
            fresh_q <= 1'b0;
        else if (dec_q)
            fresh_q <= (ftype == FT_FAST);
        else if (step)
            fresh_q <= 1'b0;
    end

    sinc_integ #(.W(ACC_W), .STAGES(STAGES)) u_integ (
        .clk    (clk),
        .clr    (clr),
        .step   (step),
        .fresh  (fresh_q),
        .bit_in (mod_data),
        .acc    (acc)
    );

    always_comb begin
        case (order)
            2'd1:    comb_in = acc[0];
            2'd2:    comb_in = acc[1];
            default: comb_in = acc[2];
        endcase
    end

    sinc_comb #(.W(ACC_W), .STAGES(STAGES)) u_comb (
        .clk   (clk),
        .clr   (clr),
        .fire  (dec_q),
        .order (order),
        .din   (comb_in),
        .dout  (comb_out)
    );

    assign full = (ftype == FT_FAST) ? acc[1] : comb_out;

    sinc_fmt #(.W(ACC_W)) u_fmt (
        .full   (full),
        .word16 (word16),
        .shift  (shift),
        .word   (fmt_word)
    );

    // Settling count and output register.
    always_ff @(posedge clk) begin
        if (clr) begin
            seen        <= '0;
            out_q.valid <= 1'b0;
        end else begin
            out_q.valid <= 1'b0;
            if (dec_q) begin
                if (seen == need)
                    out_q.valid <= 1'b1;
                else
                    seen <= seen + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q.word <= '0;
        else if (!clr && dec_q && seen == need)
            out_q.word <= fmt_word;
    end

    assign dready = out_q.valid;
    assign sample = out_q.word;

    // R12
    dready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dready |=> !dready);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !dready);

    // R11
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sync |=> !dready);

    // R9
    narrow_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (dready && $past(word16)) |-> (sample[31:16] == {16{sample[15]}}));

endmodule

// File: tb/sinc_decim_test.sv
`timescale 1ns/1ps
module sinc_decim_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        mod_clk;
    logic        mod_data;
    logic        enable;
    logic        sync;
    logic [1:0]  filt_sel;
    logic [7:0]  osr_m1;
    logic        word16;
    logic [4:0]  shift;
    logic        dready;
    logic [31:0] sample;

    always #10 clk = ~clk;

    sinc_decim uut (
        .clk(clk), .rst(rst), .mod_clk(mod_clk), .mod_data(mod_data),
        .enable(enable), .sync(sync), .filt_sel(filt_sel), .osr_m1(osr_m1),
        .word16(word16), .shift(shift), .dready(dready), .sample(sample)
    );

    int    checks = 0;
    int    fails  = 0;
    int    pulses = 0;
    bit    prev_dr = 1'b0;
    int    q_val[$];
    string q_tag[$];

    int    hist[$];
    int    kern[$];
    int    rat, ftype_m, need_m, wcnt, nout;
    logic [15:0] lfsr = 16'hACE1;

    function automatic bit rnd_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic int fmt_exp(longint y);
        longint s;
        if (word16) begin
            s = y >>> shift;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            return int'(s);
        end
        return int'(y);
    endfunction

    task automatic build_kern(int ord, int r);
        int cur[$];
        kern.delete();
        for (int i = 0; i < r; i++) kern.push_back(1);
        for (int s = 1; s < ord; s++) begin
            cur = kern;
            kern.delete();
            for (int k = 0; k < cur.size() + r - 1; k++) begin
                int a;
                a = 0;
                for (int j = 0; j < r; j++)
                    if (k - j >= 0 && k - j < cur.size()) a += cur[k-j];
                kern.push_back(a);
            end
        end
    endtask

    task automatic model_clear();
        hist.delete();
        wcnt = 0;
        nout = 0;
    endtask

    task automatic configure(int t, int r, bit w16, int sh);
        int ord;
        @(negedge clk);
        enable   = 1'b0;
        filt_sel = t[1:0];
        osr_m1   = 8'(r - 1);
        word16   = w16;
        shift    = 5'(sh);
        @(negedge clk);
        rat = r; ftype_m = t;
        ord    = (t == 0) ? 1 : (t == 3) ? 3 : 2;
        need_m = (t == 1) ? 1 : (t == 3) ? 2 : 0;
        if (t != 2) build_kern(ord, r);
        model_clear();
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic drive_bit(bit b);
        @(negedge clk);
        mod_data = b;
        mod_clk  = 1'b1;
        repeat (4) @(negedge clk);
        mod_clk  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: updates the reference model, queues the expected sample, then drives the bit.
    task automatic send_bit(bit b, string tag);
        longint y;
        hist.push_back(b ? 1 : -1);
        wcnt++;
        if (wcnt == rat) begin
            wcnt = 0;
            nout++;
            y = 0;
            if (ftype_m == 2) begin
                for (int j = 0; j < rat; j++)
                    y += longint'(rat - j) * hist[hist.size() - rat + j];
            end else begin
                for (int i = 0; i < kern.size(); i++) begin
                    int idx;
                    idx = hist.size() - 1 - i;
                    if (idx >= 0) y += longint'(kern[i]) * hist[idx];
                end
            end
            if (nout > need_m) begin
                q_val.push_back(fmt_exp(y));
                q_tag.push_back(tag);
            end
        end
        drive_bit(b);
    endtask

    task automatic send_const(bit b, int n, string tag);
        for (int i = 0; i < n; i++) send_bit(b, tag);
    endtask

    task automatic send_rand(int n, string tag);
        for (int i = 0; i < n; i++) send_bit(rnd_bit(), tag);
    endtask

    task automatic drained(string tag);
        repeat (4) @(negedge clk);
        checks++;
        if (q_val.size() != 0) begin
            fails++;
            $display("FAIL %s missing samples act=0 exp=%0d", tag, q_val.size());
            q_val.delete();
            q_tag.delete();
        end
    endtask

    // Monitor: pops and compares each produced sample.
    always @(negedge clk) begin
        if (!rst && dready) begin
            int    e;
            string t;
            pulses++;
            checks++;
            if (prev_dr) begin
                fails++;
                $display("FAIL R12 dready held act=1 exp=0");
            end
            if (q_val.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected sample act=%0d exp=none", $signed(sample));
            end else begin
                e = q_val.pop_front();
                t = q_tag.pop_front();
                if ($signed(sample) !== e) begin
                    fails++;
                    $display("FAIL %s sample act=%0d exp=%0d", t, $signed(sample), e);
                end
            end
        end
        prev_dr = dready;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        rst = 1'b1; enable = 1'b0; sync = 1'b0; mod_clk = 1'b0; mod_data = 1'b0;
        filt_sel = 2'd0; osr_m1 = 8'd0; word16 = 1'b0; shift = 5'd0;
        repeat (3) @(negedge clk);
        checks++;
        if (dready !== 1'b0 || sample !== 32'd0) begin
            fails++;
            $display("FAIL R1 reset act=%b/%0h exp=0/0", dready, sample);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (dready !== 1'b0 || sample !== 32'd0) begin
            fails++;
            $display("FAIL R1 after reset act=%b/%0h exp=0/0", dready, sample);
        end

        // R2 / R6: ratio 1, each bit is one sample
        configure(0, 1, 0, 0);
        send_rand(16, "R2");
        drained("R2");

        // R3: Sinc1 at ratio 8
        configure(0, 8, 0, 0);
        send_rand(64, "R3");
        drained("R3");

        // R4: Sinc2, alternating then random
        configure(1, 4, 0, 0);
        for (int i = 0; i < 16; i++) send_bit(i[0], "R4");
        send_rand(32, "R4");
        drained("R4");

        // R7: Sinc3 drops two samples after enable
        configure(3, 16, 0, 0);
        send_rand(96, "R7");
        drained("R7");

        // R5: fast type, ones then random
        configure(2, 8, 0, 0);
        send_const(1'b1, 16, "R5");
        send_rand(24, "R5");
        drained("R5");

        // R8: full scale Sinc3 at ratio 256 in 32-bit mode
        configure(3, 256, 0, 0);
        send_const(1'b1, 768, "R8");
        send_const(1'b0, 768, "R8");
        drained("R8");

        // R9: negative saturation and scaling
        configure(3, 256, 1, 0);
        send_const(1'b0, 768, "R9");
        shift = 5'd9;
        send_const(1'b0, 256, "R9");
        shift = 5'd10;
        send_const(1'b0, 256, "R9");
        drained("R9");

        // R9: positive saturation with Sinc2
        configure(1, 256, 1, 0);
        send_const(1'b1, 512, "R9");
        shift = 5'd2;
        send_const(1'b1, 256, "R9");
        drained("R9");

        // R9: mid-range scaled samples
        configure(3, 8, 1, 2);
        send_rand(64, "R9");
        drained("R9");

        // R10: disabled, bits ignored and no strobe
        @(negedge clk);
        enable = 1'b0;
        p0 = pulses;
        for (int i = 0; i < 40; i++) drive_bit(rnd_bit());
        checks++;
        if (pulses != p0) begin
            fails++;
            $display("FAIL R10 strobes while disabled act=%0d exp=0", pulses - p0);
        end
        configure(0, 4, 0, 0);
        send_rand(16, "R10");
        drained("R10");

        // R11: sync mid-window realigns the phase
        configure(1, 8, 0, 0);
        send_rand(3, "R11");
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        model_clear();
        send_rand(40, "R11");
        drained("R11");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule